// File: doc/BRIEF.md
# Cascaded Active-Low Priority Encoder

This block turns a bank of active-low request lines into the active-low binary index of the highest-numbered line that is asserted. Two identical stages, each covering `LINES` lines, are chained. The upper stage handles the upper half of the lines and takes the external active-low enable. Its enable output feeds the lower stage's enable, so the lower stage only encodes when no upper line is pending. The stage results are then merged into one index that is one bit wider than a single stage's index. The block also produces a combined "any request" flag and a chain output, and both are active low.

Each stage on its own is purely combinational, so its outputs can glitch while the inputs move. By default a register stage samples the merged result on every rising clock edge, which means downstream logic sees only settled codes one cycle later. The register has a synchronous active-high reset that forces every output to its inactive high level. Setting `REGISTERED` to 0 removes the register and makes the outputs follow the inputs within the same cycle.

Top module: `prienc_cascade`

## Requirements
- R1: When several request lines are low at once, only the highest-numbered one is encoded.
- R2: The index is the bitwise inverse of the winning line number: line 15 gives 4'b0000, line 8 gives 4'b0111 and line 0 gives 4'b1111 (with the default 8 lines per stage).
- R3: While `en_n` is high, `idx_n` is all ones and `grp_n` and `eo_n` are both high, whatever `req_n` carries.
- R4: With `en_n` low and every request line high, `idx_n` is all ones, `grp_n` is high and `eo_n` is low.
- R5: With `en_n` low and at least one request line low, `grp_n` is low and `eo_n` is high, so the two are never low together.
- R6: Any low line in the upper half (lines LINES to 2*LINES-1) clears the index MSB, and the lower half's lines then have no effect on the outputs.
- R7: `LINES` is a power of two (default 8), and the index width is log2(2*LINES), which is 4 bits by default.
- R8: With `REGISTERED`=1 (the default), the outputs reflect the inputs sampled at the previous rising edge of `clk`. While `rst` is high at an edge, all outputs are set high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Encoder enable, active low |
| req_n | input | 2*LINES | Request lines, active low, bit index = line number |
| idx_n | output | log2(2*LINES) | Inverted binary index of the winning line |
| grp_n | output | 1 | Low when any line is requested while enabled |
| eo_n | output | 1 | Low when enabled with no line requested (chain to a further block) |

## Verification
The only state in the block is the output register. A wrong value held there shows up on all three outputs at the very next clock edge, against the inputs applied one cycle earlier. A fault in the stage chaining, such as the lower stage being enabled while an upper line is pending, shows as a wrong index bit or a wrong flag on the first pattern that has requests in both halves. Comparing every output on every cycle, across all input patterns and both enable levels, means a fault appears within one cycle of the first pattern that exposes it.

// File: rtl/prienc_pkg.sv
package prienc_pkg;

    // Index width of a cascade of two stages with the given lines per stage.
    function automatic int cascade_idx_bits(input int lines_per_stage);
        return $clog2(2 * lines_per_stage);
    endfunction

endpackage

// File: rtl/prienc_stage.sv
module prienc_stage #(
    parameter  int LINES = 8,
    localparam int IW    = $clog2(LINES)
) (
    input  logic             en_n,
    input  logic [LINES-1:0] req_n,
    output logic [IW-1:0]    idx_n,
    output logic             grp_n,
    output logic             eo_n
);

    logic          hit;
    logic [IW-1:0] win;

    // An ascending scan lets the highest asserted line overwrite the lower ones.
    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!req_n[i]) begin
                hit = 1'b1;
                win = i[IW-1:0];
            end
        end
    end

    always_comb begin
        if (en_n) begin
            idx_n = '1;
            grp_n = 1'b1;
            eo_n  = 1'b1;
        end else if (!hit) begin
            idx_n = '1;
            grp_n = 1'b1;
            eo_n  = 1'b0;
        end else begin
            idx_n = ~win;
            grp_n = 1'b0;
            eo_n  = 1'b1;
        end
    end

endmodule

// File: rtl/prienc_join.sv
module prienc_join #(
    parameter int IW = 3
) (
    input  logic [IW-1:0] hi_idx_n,
    input  logic          hi_grp_n,
    input  logic [IW-1:0] lo_idx_n,
    input  logic          lo_grp_n,
    input  logic          lo_eo_n,
    output logic [IW:0]   idx_n,
    output logic          grp_n,
    output logic          eo_n
);

    // The disabled stage drives all ones, so an AND passes the active stage through.
    assign idx_n = {hi_grp_n, hi_idx_n & lo_idx_n};
    assign grp_n = hi_grp_n & lo_grp_n;
    assign eo_n  = lo_eo_n;

endmodule

// File: rtl/prienc_oreg.sv
module prienc_oreg #(
    parameter int W          = 6,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (REGISTERED) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '1;
                else     q_r <= d;
            end
            assign q = q_r;
        end else begin : g_comb
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/prienc_cascade.sv
module prienc_cascade
    import prienc_pkg::*;
#(
    parameter  int LINES      = 8,
    parameter  bit REGISTERED = 1'b1,
    localparam int SW         = $clog2(LINES),
    localparam int OW         = SW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_n,
    input  logic [2*LINES-1:0] req_n,
    output logic [OW-1:0]      idx_n,
    output logic               grp_n,
    output logic               eo_n
);

    localparam int CHK_OW = cascade_idx_bits(LINES);
    localparam int RW     = CHK_OW + 2;

    logic [SW-1:0] hi_idx_n, lo_idx_n;
    logic          hi_grp_n, hi_eo_n, lo_grp_n, lo_eo_n;
    logic [OW-1:0] mrg_idx_n;
    logic          mrg_grp_n, mrg_eo_n;
    logic [RW-1:0] res_d, res_q;

    prienc_stage #(.LINES(LINES)) u_hi (
        .en_n  (en_n),
        .req_n (req_n[2*LINES-1:LINES]),
        .idx_n (hi_idx_n),
        .grp_n (hi_grp_n),
        .eo_n  (hi_eo_n)
    );

    prienc_stage #(.LINES(LINES)) u_lo (
        .en_n  (hi_eo_n),
        .req_n (req_n[LINES-1:0]),
        .idx_n (lo_idx_n),
        .grp_n (lo_grp_n),
        .eo_n  (lo_eo_n)
    );

    prienc_join #(.IW(SW)) u_join (
        .hi_idx_n (hi_idx_n),
        .hi_grp_n (hi_grp_n),
        .lo_idx_n (lo_idx_n),
        .lo_grp_n (lo_grp_n),
        .lo_eo_n  (lo_eo_n),
        .idx_n    (mrg_idx_n),
        .grp_n    (mrg_grp_n),
        .eo_n     (mrg_eo_n)
    );

    assign res_d = {mrg_idx_n, mrg_grp_n, mrg_eo_n};

    prienc_oreg #(.W(RW), .REGISTERED(REGISTERED)) u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (res_d),
        .q   (res_q)
    );

    assign idx_n = res_q[RW-1:2];
    assign grp_n = res_q[1];
    assign eo_n  = res_q[0];

endmodule

// File: rtl/prienc_cascade_chk.sv
module prienc_cascade_chk #(
    parameter  int LINES      = 8,
    parameter  bit REGISTERED = 1'b1,
    localparam int OW         = $clog2(LINES) + 1
) (
    input logic               clk,
    input logic               rst,
    input logic               en_n,
    input logic [2*LINES-1:0] req_n,
    input logic [OW-1:0]      idx_n,
    input logic               grp_n,
    input logic               eo_n
);

    logic               vld;
    logic               en_s;
    logic [2*LINES-1:0] req_s;

    generate
        if (REGISTERED) begin : g_lag
            logic               vld_q = 1'b0;
            logic               en_q  = 1'b1;
            logic [2*LINES-1:0] req_q = '1;
            always_ff @(posedge clk) begin
                vld_q <= !rst;
                en_q  <= en_n;
                req_q <= req_n;
            end
            assign vld   = vld_q;
            assign en_s  = en_q;
            assign req_s = req_q;

            // R8
            reset_high_chk: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (idx_n == '1 && grp_n && eo_n));
        end else begin : g_now
            assign vld   = 1'b1;
            assign en_s  = en_n;
            assign req_s = req_n;
        end
    endgenerate

    // R3
    disabled_high_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && en_s) |-> (idx_n == '1 && grp_n && eo_n));

    // R4
    idle_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !en_s && req_s == '1) |-> (idx_n == '1 && grp_n && !eo_n));

    // R5
    flag_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !en_s && req_s != '1) |-> (!grp_n && eo_n));

    // R6
    upper_first_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !en_s && req_s[2*LINES-1:LINES] != '1) |-> !idx_n[OW-1]);

endmodule

bind prienc_cascade prienc_cascade_chk #(.LINES(LINES), .REGISTERED(REGISTERED)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en_n  (en_n),
    .req_n (req_n),
    .idx_n (idx_n),
    .grp_n (grp_n),
    .eo_n  (eo_n)
);

// File: tb/prienc_cascade_bench.sv
module prienc_cascade_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_n = 1'b1;
    logic [15:0] req_n = '1;
    logic [3:0]  idx_n;
    logic        grp_n;
    logic        eo_n;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    prienc_cascade u_prienc_cascade (
        .clk   (clk),
        .rst   (rst),
        .en_n  (en_n),
        .req_n (req_n),
        .idx_n (idx_n),
        .grp_n (grp_n),
        .eo_n  (eo_n)
    );

    // Behavioural reference: {idx[3:0], grp, eo}, scanning line 15 down to 0.
    function automatic logic [5:0] model(input logic en, input logic [15:0] req);
        if (en) return 6'b111111;
        for (int k = 15; k >= 0; k--) begin
            if (!req[k]) return {~k[3:0], 1'b0, 1'b1};
        end
        return {4'hF, 1'b1, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [5:0] exp);
        logic [5:0] act;
        act = {idx_n, grp_n, eo_n};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {idx_n,grp_n,eo_n} actual=%b expected=%b (en_n=%b req_n=%h)",
                     tag, act, exp, en_n, req_n);
        end
    endtask

    function automatic string tag_for(input logic en, input logic [15:0] req);
        if (en)               return "R3";
        if (req == 16'hFFFF)  return "R4";
        if (req[15:8] != 8'hFF) return "R6";
        if (req[7:0] != 8'hFF && $countones(~req[7:0]) > 1) return "R1";
        return "R2";
    endfunction

    initial begin : watchdog
        #(4 * 180000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        logic [5:0] prev_exp;
        string      prev_tag;
        logic       have_prev;

        // R8: outputs high during reset even with enable and a request low
        en_n  = 1'b0;
        req_n = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", 6'b111111);

        // R7: index width derived from lines per stage
        tests++;
        if ($bits(idx_n) != 4) begin
            fails++;
            $display("FAIL R7: index width actual=%0d expected=4", $bits(idx_n));
        end

        rst = 1'b0;
        have_prev = 1'b0;
        prev_exp  = '1;
        prev_tag  = "";
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 65536; p++) begin
                @(negedge clk);
                if (have_prev) check(prev_tag, prev_exp);
                en_n      = e[0];
                req_n     = p[15:0];
                prev_exp  = model(e[0], p[15:0]);
                prev_tag  = tag_for(e[0], p[15:0]);
                have_prev = 1'b1;
            end
        end
        @(negedge clk);
        check(prev_tag, prev_exp);

        // R5: a single low line in each half, grp low and eo high
        en_n  = 1'b0;
        req_n = 16'hFFFE;
        @(negedge clk);
        check("R5", 6'b111101);
        req_n = 16'h7FFF;
        @(negedge clk);
        check("R5", 6'b000001);

        // R8: one-cycle latency, previous value held until the edge
        req_n = 16'hFFFF;
        #1;
        check("R8", 6'b000001);
        @(negedge clk);
        check("R8", 6'b111110);

        // R8: synchronous reset mid-run forces outputs high
        req_n = 16'h0000;
        rst   = 1'b1;
        @(negedge clk);
        check("R8", 6'b111111);
        rst = 1'b0;
        @(negedge clk);
        check("R6", 6'b000001);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule